// File: doc/BRIEF.md
# Atomic Read-Modify-Write Sequencer with Reservation

This block sits between one core's load/store port and a plain word-addressed memory. It carries out word-sized atomic requests one at a time.

- **Load-reserved** reads a word, returns it and records a reservation on that word.
- **Store-conditional** writes its operand only while that reservation is still held. It answers 0 on success and 1 on failure.
- **Fetch-and-op** requests (nine of them) read the word, combine it with the operand, write the result back to the same word and return the old value.

A second input carries ordinary stores from other agents. A store to the reserved word cancels the reservation. Every request carries acquire and release flags. All four combinations are accepted, and the flags do not change the result or the timing.

The sequencer has six states:

| State | What happens | Next state |
|---|---|---|
| `ST_IDLE` | The unit accepts a request. | A bad request goes to `ST_RESP`. A store-conditional goes to `ST_COND`. Every other request goes to `ST_READ`. |
| `ST_READ` | The memory read is issued. | A load-reserved goes to `ST_LATCH`. A fetch-and-op goes to `ST_MODIFY`. |
| `ST_MODIFY` | The combined value is written back. | `ST_RESP` |
| `ST_LATCH` | The read word is captured and the reservation is set. | `ST_RESP` |
| `ST_COND` | The store-conditional writes or fails, and the reservation is dropped. | `ST_RESP` |
| `ST_RESP` | The single response cycle. | `ST_IDLE` |

Memory returns read data one cycle after a read enable.

Top module: `rmw_atomic_unit`

## Requirements
- R1: After reset, req_ready is 1, rsp_valid is 0, mem_en is 0 and no reservation is held, so a first store-conditional fails.
- R2: Load-reserved (op code 0) returns the addressed word with rsp_err 0. It records a reservation on that word. Its response comes 3 cycles after the accepting cycle.
- R3: Store-conditional (op code 1) to the reserved word writes req_wdata to that word and returns 0. Its response comes 2 cycles after the accepting cycle.
- R4: Store-conditional with no reservation, or to a different word, returns 1 and performs no memory write.
- R5: Every store-conditional, passing or failing, clears the reservation.
- R6: A snoop store (snoop_valid with snoop_addr as a word index) to the reserved word clears the reservation. A snoop to any other word leaves it held.
- R7: The fetch-and-op codes are as follows. Each returns the old word, and memory receives the combined value.

  | Code | Operation | Value written |
  |---|---|---|
  | 2 | swap | the operand |
  | 3 | add | old + operand |
  | 4 | and | old & operand |
  | 5 | or | old \| operand |
  | 6 | xor | old ^ operand |
  | 7 | signed min | smaller of the two as signed |
  | 8 | signed max | larger of the two as signed |
  | 9 | unsigned min | smaller of the two as unsigned |
  | 10 | unsigned max | larger of the two as unsigned |

- R8: A fetch-and-op takes one read cycle, then exactly one write cycle to the same word, then the response 3 cycles after acceptance. req_ready stays 0 from acceptance through the response cycle.
- R9: A byte address with req_addr[1:0] not 00 gives rsp_err 1 and rsp_data 0 one cycle after acceptance. It makes no memory access and leaves the reservation unchanged.
- R10: req_aq and req_rl in any combination leave the returned data, the memory result and the latency unchanged.
- R11: Op codes 11 to 15 are answered like a misaligned request: rsp_err 1, rsp_data 0 one cycle after acceptance, and no memory access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit idle, request taken this cycle |
| req_op | input | 4 | Operation code (see R2, R3, R7, R11) |
| req_addr | input | AW | Byte address |
| req_wdata | input | DW | Second operand / store data |
| req_aq | input | 1 | Acquire flag |
| req_rl | input | 1 | Release flag |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_data | output | DW | Old word, or store-conditional code |
| rsp_err | output | 1 | Misaligned or unknown request |
| mem_en | output | 1 | Memory access enable |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | AW-2 | Memory word index |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data, one cycle after a read |
| snoop_valid | input | 1 | Foreign store observed |
| snoop_addr | input | AW-2 | Word index of the foreign store |

## Verification
Errors in the reservation register do not show up at once. They surface only at the next store-conditional, as a 0 where a 1 was due or the reverse, together with a memory write that should not happen or a write that is missing. The bench therefore follows every reservation change with a store-conditional and counts memory writes.

A sequencer that branches to the wrong state shows up within three cycles, as a wrong response latency or a second write strobe. A wrong combine function shows in the stored word on the write cycle of the same request. That word is checked against values computed in the bench for every operation over a grid of operands.

// File: rtl/rmw_pkg.sv
`timescale 1ns/1ps
package rmw_pkg;

    typedef enum logic [3:0] {
        OP_LR   = 4'd0,
        OP_SC   = 4'd1,
        OP_SWAP = 4'd2,
        OP_ADD  = 4'd3,
        OP_AND  = 4'd4,
        OP_OR   = 4'd5,
        OP_XOR  = 4'd6,
        OP_MIN  = 4'd7,
        OP_MAX  = 4'd8,
        OP_MINU = 4'd9,
        OP_MAXU = 4'd10
    } op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_MODIFY,
        ST_LATCH,
        ST_COND,
        ST_RESP
    } state_e;

    function automatic logic op_known(input logic [3:0] code);
        return code <= OP_MAXU;
    endfunction

endpackage

// File: rtl/rmw_combine.sv
`timescale 1ns/1ps
module rmw_combine
    import rmw_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic [3:0]    op,
    input  logic [DW-1:0] old_word,
    input  logic [DW-1:0] operand,
    output logic [DW-1:0] result
);
    logic s_less;
    logic u_less;

    assign s_less = $signed(old_word) < $signed(operand);
    assign u_less = old_word < operand;

    always_comb begin
        result = operand;
        case (op_e'(op))
            OP_ADD:  result = old_word + operand;
            OP_AND:  result = old_word & operand;
            OP_OR:   result = old_word | operand;
            OP_XOR:  result = old_word ^ operand;
            OP_MIN:  result = s_less ? old_word : operand;
            OP_MAX:  result = s_less ? operand  : old_word;
            OP_MINU: result = u_less ? old_word : operand;
            OP_MAXU: result = u_less ? operand  : old_word;
            default: result = operand;
        endcase
    end
endmodule

// File: rtl/rmw_reservation.sv
`timescale 1ns/1ps
module rmw_reservation #(
    parameter int WAW = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           set,
    input  logic           drop,
    input  logic [WAW-1:0] word,
    input  logic           snoop_valid,
    input  logic [WAW-1:0] snoop_word,
    output logic           held
);
    logic           live;
    logic [WAW-1:0] tag;
    logic           snoop_hits_tag;
    logic           snoop_hits_new;

    assign snoop_hits_tag = snoop_valid && live && (snoop_word == tag);
    assign snoop_hits_new = snoop_valid && (snoop_word == word);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            live <= 1'b0;
            tag  <= '0;
        end else if (set) begin
            live <= !snoop_hits_new;
            tag  <= word;
        end else if (drop || snoop_hits_tag) begin
            live <= 1'b0;
        end
    end

    // a foreign store in the same cycle is taken to come first
    assign held = live && (tag == word) && !snoop_hits_tag;
endmodule

// File: rtl/rmw_atomic_unit.sv
`timescale 1ns/1ps
module rmw_atomic_unit
    import rmw_pkg::*;
#(
    parameter int AW  = 10,
    parameter int DW  = 32,
    localparam int WAW = AW - 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           req_valid,
    output logic           req_ready,
    input  logic [3:0]     req_op,
    input  logic [AW-1:0]  req_addr,
    input  logic [DW-1:0]  req_wdata,
    input  logic           req_aq,
    input  logic           req_rl,
    output logic           rsp_valid,
    output logic [DW-1:0]  rsp_data,
    output logic           rsp_err,
    output logic           mem_en,
    output logic           mem_we,
    output logic [WAW-1:0] mem_addr,
    output logic [DW-1:0]  mem_wdata,
    input  logic [DW-1:0]  mem_rdata,
    input  logic           snoop_valid,
    input  logic [WAW-1:0] snoop_addr
);
    state_e         state, state_nx;
    logic [3:0]     op_q;
    logic [WAW-1:0] word_q;
    logic [DW-1:0]  opnd_q;
    logic [DW-1:0]  data_q;
    logic           err_q;
    logic           bad_req;
    logic           resv_held;
    logic [DW-1:0]  combined;

    assign bad_req = (req_addr[1:0] != 2'b00) || !op_known(req_op);

    rmw_combine #(.DW(DW)) u_combine (
        .op       (op_q),
        .old_word (mem_rdata),
        .operand  (opnd_q),
        .result   (combined)
    );

    rmw_reservation #(.WAW(WAW)) u_resv (
        .clk         (clk),
        .rst_n       (rst_n),
        .set         (state == ST_LATCH),
        .drop        (state == ST_COND),
        .word        (word_q),
        .snoop_valid (snoop_valid),
        .snoop_word  (snoop_addr),
        .held        (resv_held)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (req_valid) begin
                    if (bad_req)             state_nx = ST_RESP;
                    else if (req_op == OP_SC) state_nx = ST_COND;
                    else                      state_nx = ST_READ;
                end
            end
            ST_READ:   state_nx = (op_q == OP_LR) ? ST_LATCH : ST_MODIFY;
            ST_MODIFY: state_nx = ST_RESP;
            ST_LATCH:  state_nx = ST_RESP;
            ST_COND:   state_nx = ST_RESP;
            ST_RESP:   state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    // request capture and result holding
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q   <= '0;
            word_q <= '0;
            opnd_q <= '0;
            data_q <= '0;
            err_q  <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        op_q   <= req_op;
                        word_q <= req_addr[AW-1:2];
                        opnd_q <= req_wdata;
                        err_q  <= bad_req;
                        data_q <= '0;
                    end
                end
                ST_MODIFY, ST_LATCH: data_q <= mem_rdata;
                ST_COND:             data_q <= resv_held ? '0 : DW'(1);
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        req_ready = 1'b0;
        rsp_valid = 1'b0;
        rsp_data  = '0;
        rsp_err   = 1'b0;
        mem_en    = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = word_q;
        mem_wdata = opnd_q;
        unique case (state)
            ST_IDLE:  req_ready = 1'b1;
            ST_READ:  mem_en = 1'b1;
            ST_MODIFY: begin
                mem_en    = 1'b1;
                mem_we    = 1'b1;
                mem_wdata = combined;
            end
            ST_LATCH: ;
            ST_COND: begin
                mem_en = resv_held;
                mem_we = resv_held;
            end
            ST_RESP: begin
                rsp_valid = 1'b1;
                rsp_data  = data_q;
                rsp_err   = err_q;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/rmw_atomic_unit_chk.sv
`timescale 1ns/1ps
module rmw_atomic_unit_chk #(
    parameter int AW  = 10,
    parameter int DW  = 32,
    parameter int WAW = AW - 2
) (
    input logic           clk,
    input logic           rst_n,
    input logic           req_valid,
    input logic           req_ready,
    input logic [AW-1:0]  req_addr,
    input logic           req_aq,
    input logic           req_rl,
    input logic           rsp_valid,
    input logic [DW-1:0]  rsp_data,
    input logic           rsp_err,
    input logic           mem_en,
    input logic           mem_we,
    input logic [WAW-1:0] mem_addr
);
    p_reset_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (req_ready && !rsp_valid && !mem_en));

    p_single_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    p_rsp_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> (!rsp_valid && req_ready));

    p_mem_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_en |-> !req_ready);

    p_same_word_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && $past(mem_en && !mem_we)) |-> (mem_addr == $past(mem_addr)));

    p_single_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> !mem_we);

    p_err_clean_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> (rsp_valid && rsp_data == '0));

    p_misalign_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_addr[1:0] != 2'b00) |=> (!mem_en && rsp_valid && rsp_err));

    p_flags_known_r10: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> !$isunknown({req_aq, req_rl}));
endmodule

bind rmw_atomic_unit rmw_atomic_unit_chk #(.AW(AW), .DW(DW), .WAW(WAW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_addr  (req_addr),
    .req_aq    (req_aq),
    .req_rl    (req_rl),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_data),
    .rsp_err   (rsp_err),
    .mem_en    (mem_en),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr)
);

// File: tb/rmw_atomic_unit_test.sv
`timescale 1ns/1ps
module rmw_atomic_unit_test;
    localparam int AW  = 10;
    localparam int DW  = 32;
    localparam int WAW = AW - 2;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           req_valid = 1'b0;
    logic           req_ready;
    logic [3:0]     req_op = '0;
    logic [AW-1:0]  req_addr = '0;
    logic [DW-1:0]  req_wdata = '0;
    logic           req_aq = 1'b0;
    logic           req_rl = 1'b0;
    logic           rsp_valid;
    logic [DW-1:0]  rsp_data;
    logic           rsp_err;
    logic           mem_en;
    logic           mem_we;
    logic [WAW-1:0] mem_addr;
    logic [DW-1:0]  mem_wdata;
    logic [DW-1:0]  mem_rdata;
    logic           snoop_valid = 1'b0;
    logic [WAW-1:0] snoop_addr = '0;

    logic [DW-1:0]  mem [0:(1<<WAW)-1];
    logic           pl_en = 1'b0;
    logic [WAW-1:0] pl_addr = '0;
    logic [DW-1:0]  pl_data = '0;
    int             writes = 0;
    int             total = 0;
    int             failed = 0;
    bit             done = 1'b0;

    always #2 clk = ~clk;

    rmw_atomic_unit #(.AW(AW), .DW(DW)) uut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_aq(req_aq), .req_rl(req_rl),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_err(rsp_err),
        .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .snoop_valid(snoop_valid), .snoop_addr(snoop_addr)
    );

    // memory model: one-cycle read latency, bench preload port
    always @(posedge clk) begin
        if (pl_en) mem[pl_addr] <= pl_data;
        else if (mem_en && mem_we) begin
            mem[mem_addr] <= mem_wdata;
            writes <= writes + 1;
        end
        if (mem_en && !mem_we) mem_rdata <= mem[mem_addr];
    end

    task automatic check(input bit ok, input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        total++;
        if (!ok) begin
            failed++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic preload(input logic [WAW-1:0] w, input logic [DW-1:0] v);
        @(negedge clk);
        pl_en = 1'b1; pl_addr = w; pl_data = v;
        @(negedge clk);
        pl_en = 1'b0;
    endtask

    task automatic do_req(input logic [3:0] op, input logic [AW-1:0] a, input logic [DW-1:0] wd,
                          input logic aq, input logic rl,
                          output logic [DW-1:0] d, output logic e, output int lat);
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_addr = a; req_wdata = wd; req_aq = aq; req_rl = rl;
        lat = 0;
        do begin
            @(negedge clk);
            req_valid = 1'b0;
            lat++;
        end while (!rsp_valid && lat < 20);
        d = rsp_data;
        e = rsp_err;
    endtask

    task automatic snoop(input logic [WAW-1:0] w);
        @(negedge clk);
        snoop_valid = 1'b1; snoop_addr = w;
        @(negedge clk);
        snoop_valid = 1'b0;
    endtask

    function automatic logic [DW-1:0] model(input int op, input logic [DW-1:0] a, input logic [DW-1:0] b);
        case (op)
            2:  return b;
            3:  return a + b;
            4:  return a & b;
            5:  return a | b;
            6:  return a ^ b;
            7:  return ($signed(a) < $signed(b)) ? a : b;
            8:  return ($signed(a) > $signed(b)) ? a : b;
            9:  return (a < b) ? a : b;
            default: return (a > b) ? a : b;
        endcase
    endfunction

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; failed++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("%0d/%0d checks passed", total - failed, total);
            $finish;
        end
    end

    initial begin : main
        logic [DW-1:0] d;
        logic          e;
        int            lat;
        int            w0;
        logic [DW-1:0] vals [6];
        logic [DW-1:0] ref_d [4];
        logic [DW-1:0] ref_m [4];
        vals[0] = 32'h0000_0000; vals[1] = 32'h0000_0001; vals[2] = 32'h7fff_ffff;
        vals[3] = 32'h8000_0000; vals[4] = 32'hffff_ffff; vals[5] = 32'h1234_5678;
        for (int i = 0; i < (1<<WAW); i++) mem[i] = 32'h0;

        repeat (3) @(negedge clk);
        check(req_ready && !rsp_valid && !mem_en, "R1 reset outputs", {req_ready, rsp_valid, mem_en}, 3'b100);
        rst_n = 1'b1;

        // R1/R4: no reservation after reset
        preload(8'd5, 32'haaaa_0005);
        w0 = writes;
        do_req(4'd1, {8'd5, 2'b00}, 32'hdead_beef, 0, 0, d, e, lat);
        check(d == 1 && !e, "R1 first SC fails", d, 1);
        check(writes == w0 && mem[5] == 32'haaaa_0005, "R4 failed SC no write", mem[5], 32'haaaa_0005);

        // R2 load-reserved
        do_req(4'd0, {8'd5, 2'b00}, 0, 0, 0, d, e, lat);
        check(d == 32'haaaa_0005 && !e, "R2 LR data", d, 32'haaaa_0005);
        check(lat == 3, "R2 LR latency", lat, 3);

        // R3 SC success
        w0 = writes;
        do_req(4'd1, {8'd5, 2'b00}, 32'h0bad_cafe, 0, 0, d, e, lat);
        check(d == 0 && !e, "R3 SC success code", d, 0);
        check(lat == 2, "R3 SC latency", lat, 2);
        check(mem[5] == 32'h0bad_cafe && writes == w0 + 1, "R3 SC stored", mem[5], 32'h0bad_cafe);

        // R5 second SC fails after success
        w0 = writes;
        do_req(4'd1, {8'd5, 2'b00}, 32'h1111_1111, 0, 0, d, e, lat);
        check(d == 1, "R5 SC after SC fails", d, 1);
        check(writes == w0 && mem[5] == 32'h0bad_cafe, "R5 no write", mem[5], 32'h0bad_cafe);

        // R4 SC to other word fails; R5 it clears the reservation
        do_req(4'd0, {8'd5, 2'b00}, 0, 0, 0, d, e, lat);
        w0 = writes;
        do_req(4'd1, {8'd6, 2'b00}, 32'h2222_2222, 0, 0, d, e, lat);
        check(d == 1 && writes == w0, "R4 SC other word fails", d, 1);
        do_req(4'd1, {8'd5, 2'b00}, 32'h3333_3333, 0, 0, d, e, lat);
        check(d == 1 && writes == w0, "R5 failed SC cleared reservation", d, 1);

        // R6 snoop to another word keeps the reservation
        do_req(4'd0, {8'd9, 2'b00}, 0, 0, 0, d, e, lat);
        snoop(8'd10);
        do_req(4'd1, {8'd9, 2'b00}, 32'h4444_4444, 0, 0, d, e, lat);
        check(d == 0 && mem[9] == 32'h4444_4444, "R6 unrelated snoop keeps", d, 0);
        // R6 snoop to the reserved word clears it
        do_req(4'd0, {8'd9, 2'b00}, 0, 0, 0, d, e, lat);
        snoop(8'd9);
        w0 = writes;
        do_req(4'd1, {8'd9, 2'b00}, 32'h5555_5555, 0, 0, d, e, lat);
        check(d == 1 && writes == w0 && mem[9] == 32'h4444_4444, "R6 matching snoop clears", d, 1);

        // R7/R8 sweep of every fetch-and-op over the operand grid
        for (int op = 2; op <= 10; op++) begin
            for (int i = 0; i < 6; i++) begin
                for (int j = 0; j < 6; j++) begin
                    logic [WAW-1:0] w;
                    logic [DW-1:0]  exp;
                    w = WAW'(16 + op * 17 + i * 6 + j);
                    exp = model(op, vals[i], vals[j]);
                    preload(w, vals[i]);
                    w0 = writes;
                    do_req(4'(op), {w, 2'b00}, vals[j], 0, 0, d, e, lat);
                    check(d == vals[i] && !e, "R7 returns old word", d, vals[i]);
                    check(mem[w] == exp, "R7 stored combined value", mem[w], exp);
                    check(lat == 3 && writes == w0 + 1, "R8 latency and single write", lat, 3);
                end
            end
        end

        // R9 misaligned addresses; reservation must survive them
        do_req(4'd0, {8'd20, 2'b00}, 0, 0, 0, d, e, lat);
        for (int off = 1; off < 4; off++) begin
            for (int op = 0; op < 4; op++) begin
                w0 = writes;
                do_req(4'(op), {8'd20, 2'(off)}, 32'h9999_9999, 0, 0, d, e, lat);
                check(e && d == 0, "R9 misaligned error", {31'b0, e}, 1);
                check(lat == 1 && writes == w0, "R9 misaligned quiet", lat, 1);
            end
        end
        do_req(4'd1, {8'd20, 2'b00}, 32'h7777_7777, 0, 0, d, e, lat);
        check(d == 0 && mem[20] == 32'h7777_7777, "R9 reservation unchanged", d, 0);

        // R11 unknown op codes
        for (int op = 11; op < 16; op++) begin
            w0 = writes;
            do_req(4'(op), {8'd21, 2'b00}, 32'h1, 0, 0, d, e, lat);
            check(e && d == 0 && lat == 1 && writes == w0, "R11 unknown op rejected", {31'b0, e}, 1);
        end

        // R10 acquire/release flags have no effect
        for (int f = 0; f < 4; f++) begin
            preload(8'd30, 32'h0000_0100);
            do_req(4'd3, {8'd30, 2'b00}, 32'h0000_0023, f[1], f[0], d, e, lat);
            ref_d[f] = d;
            ref_m[f] = mem[30];
            check(d == 32'h100 && ref_m[f] == 32'h123 && lat == 3 && !e, "R10 flags ignored", ref_m[f], 32'h123);
        end
        for (int f = 1; f < 4; f++)
            check(ref_d[f] == ref_d[0] && ref_m[f] == ref_m[0], "R10 flags match", ref_m[f], ref_m[0]);

        done = 1'b1;
        $display("%0d/%0d checks passed", total - failed, total);
        $finish;
    end
endmodule